// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the software-visible control state for one channel of a disk controller's bus-master DMA engine. A host reaches it through a small byte-addressed window of eight bytes. The host uses separate read and write strobes, a two-bit access size and a 32-bit data bus. Narrow accesses use the low lanes of the bus. The window holds three things: a command byte that starts and stops transfers and sets their direction, a status byte with the progress and event flags, and a 32-bit pointer to the descriptor table.

A 0-to-1 change of the run bit, written by software, sends a one-cycle start pulse to the disk-side DMA engine, together with the current descriptor pointer. A 1-to-0 change sends a one-cycle abort pulse. When the engine finishes, it pulses a completion input, with an optional error qualifier. The completion stops the channel and raises the interrupt flag. Software then acknowledges the event by writing ones to the event bits.

Accesses whose size or offset does not match a register raise a sticky error flag. Such an access changes no register.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset the command byte (offset 0) reads 0x00, the status byte (offset 2) reads 0x60, the pointer (offset 4) reads 0, and both irq_pend and acc_err are 0.
- R2: A word write (reg_size=2) at offset 4 stores reg_wdata with bits [1:0] forced to 0.
- R3: A legal command write that changes bit 0 (run) from 0 to 1 sets status bit 0 (active). In the next cycle it drives dma_start high for exactly one cycle, with dma_desc_ptr equal to the stored pointer.
- R4: A legal command write that changes run from 1 to 0 clears active and drives dma_abort high for one cycle. dma_start stays low.
- R5: Command bit 3 (direction, also driven on xfer_dir) keeps its value for any command write made while run is 1.
- R6: Status writes cannot change active (status bit 0).
- R7: Status bit 2 (interrupt) and bit 1 (DMA error) are cleared by writing 1 to them. Writing 0 leaves them unchanged. irq_pend mirrors bit 2.
- R8: A dma_done pulse clears run and active and sets the interrupt bit. If dma_done_err is also high, it sets the error bit as well. A command write in the same cycle as dma_done is discarded, and no start pulse is issued.
- R9: Command and status writes must be byte sized (reg_size=0) and pointer writes word sized. Any other write, or any read that is misaligned or of size code 3, sets acc_err, changes no register, and such a read returns 0. acc_err then stays 1 until reset.
- R10: A legal read returns the addressed bytes in little-endian order on reg_rdata, one cycle after reg_rd. Offsets 1 and 3 read as 0, and unused upper lanes read as 0.
- R11: Status bits 6:5 (DMA-capable) are ordinary read/write bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Byte offset in the window |
| reg_size | input | 2 | 0 byte, 1 half, 2 word, 3 illegal |
| reg_wdata | input | 32 | Write data, low lanes first |
| reg_rdata | output | 32 | Read data |
| acc_err | output | 1 | Sticky illegal-access flag |
| dma_start | output | 1 | One-cycle start pulse to DMA engine |
| dma_abort | output | 1 | One-cycle abort pulse to DMA engine |
| dma_desc_ptr | output | 32 | Descriptor pointer captured at start |
| xfer_dir | output | 1 | Transfer direction bit |
| dma_done | input | 1 | Completion pulse from DMA engine |
| dma_done_err | input | 1 | Completion ended with an error |
| irq_pend | output | 1 | Interrupt-status flag |

## Verification
The bench builds the block with its default parameters:
- a registered read path;
- both DMA-capable bits resetting to 1;
- two forced-zero pointer bits.

With these values the one-cycle read latency, the 0x60 reset status value and the masking of a pointer written with odd low bits can all be observed.

The scenarios cover several cases:
- a start, then a rewrite while running, then an abort;
- a restart followed by a completion with error, with acknowledgements that write zeros and then ones;
- a completion that collides with a command write;
- illegal sizes and alignments, followed by legal accesses to show that the error flag persists.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   localparam logic [2:0] OFS_CMD  = 3'd0;
   localparam logic [2:0] OFS_STAT = 3'd2;
   localparam logic [2:0] OFS_PTR  = 3'd4;

   localparam int CMD_RUN_BIT  = 0;
   localparam int CMD_DIR_BIT  = 3;
   localparam int STAT_ACT_BIT = 0;
   localparam int STAT_ERR_BIT = 1;
   localparam int STAT_IRQ_BIT = 2;
   localparam int STAT_CAP_LO  = 5;
endpackage

// File: rtl/bmdma_access_check.sv
module bmdma_access_check
   import bmdma_pkg::*;
(
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [2:0] addr,
   input  logic [1:0] size,
   output logic       wr_cmd,
   output logic       wr_stat,
   output logic       wr_ptr,
   output logic       rd_ok,
   output logic       bad_acc
);
   acc_size_e sz;
   logic      aligned;

   always_comb begin
      sz = acc_size_e'(size);
      unique case (sz)
         SZ_BYTE: aligned = 1'b1;
         SZ_HALF: aligned = (addr[0] == 1'b0);
         SZ_WORD: aligned = (addr[1:0] == 2'b00);
         default: aligned = 1'b0;
      endcase
      wr_cmd  = wr_en && (addr == OFS_CMD)  && (sz == SZ_BYTE);
      wr_stat = wr_en && (addr == OFS_STAT) && (sz == SZ_BYTE);
      wr_ptr  = wr_en && (addr == OFS_PTR)  && (sz == SZ_WORD);
      rd_ok   = rd_en && aligned;
      bad_acc = (wr_en && !(wr_cmd || wr_stat || wr_ptr)) || (rd_en && !aligned);
   end
endmodule

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg #(
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             wr_run,
   input  logic             wr_dir,
   input  logic             done,
   input  logic [PTR_W-1:0] ptr,
   output logic             run,
   output logic             dir,
   output logic             run_rise,
   output logic             run_fall,
   output logic             start_p,
   output logic             abort_p,
   output logic [PTR_W-1:0] start_ptr
);
   logic take;

   always_comb begin
      take     = wr && !done;
      run_rise = take && !run && wr_run;
      run_fall = take && run && !wr_run;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run       <= 1'b0;
         dir       <= 1'b0;
         start_p   <= 1'b0;
         abort_p   <= 1'b0;
         start_ptr <= '0;
      end else begin
         start_p <= run_rise;
         abort_p <= run_fall;
         if (run_rise) start_ptr <= ptr;
         if (done) begin
            run <= 1'b0;
         end else if (take) begin
            run <= wr_run;
            if (!run) dir <= wr_dir;
         end
      end
   end

   // R5: direction frozen while running
   p_dir_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(dir));
   // R8: completion always stops the channel
   p_done_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!run && !start_p));
   // R3: a start pulse only follows a stopped channel
   p_start_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |-> (run && !$past(run)));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg #(
   parameter logic [1:0] CAP_RST = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       wr_err,
   input  logic       wr_irq,
   input  logic [1:0] wr_cap,
   input  logic       act_set,
   input  logic       act_clr,
   input  logic       done,
   input  logic       done_err,
   output logic       act,
   output logic       err,
   output logic       irq,
   output logic [1:0] cap
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act <= 1'b0;
         err <= 1'b0;
         irq <= 1'b0;
         cap <= CAP_RST;
      end else begin
         if (done || act_clr) act <= 1'b0;
         else if (act_set)    act <= 1'b1;

         if (done) irq <= 1'b1;
         else if (wr && wr_irq) irq <= 1'b0;

         if (done && done_err) err <= 1'b1;
         else if (wr && wr_err) err <= 1'b0;

         if (wr) cap <= wr_cap;
      end
   end

   // R6: software never moves the active bit
   p_act_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !act_set && !act_clr && !done) |=> $stable(act));
   // R7: writing zero keeps the interrupt flag
   p_irq_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wr_irq && !done) |=> $stable(irq));
   // R7: writing zero keeps the error flag
   p_err_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wr_err && !done) |=> $stable(err));
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
   import bmdma_pkg::*;
#(
   parameter int         DATA_W    = 32,
   parameter int         PTR_ALIGN = 2,
   parameter logic [1:0] CAP_RST   = 2'b11,
   parameter bit         RDATA_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [1:0]        reg_size,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              acc_err,
   output logic              dma_start,
   output logic              dma_abort,
   output logic [DATA_W-1:0] dma_desc_ptr,
   output logic              xfer_dir,
   input  logic              dma_done,
   input  logic              dma_done_err,
   output logic              irq_pend
);
   localparam int NBYTES    = DATA_W / 8;
   localparam int WIN_BYTES = 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("bmdma_chan_regs: DATA_W must be 32");
   end
   if (PTR_ALIGN < 1 || PTR_ALIGN > 8) begin : g_bad_align
      $error("bmdma_chan_regs: PTR_ALIGN out of range");
   end

   logic wr_cmd, wr_stat, wr_ptr, rd_ok, bad_acc;
   logic run, dir, run_rise, run_fall;
   logic act, err, irq;
   logic [1:0] cap;
   logic [DATA_W-1:0] ptr_q;
   logic [DATA_W-1:0] rd_word;
   logic [7:0] win [WIN_BYTES];

   bmdma_access_check u_chk (
      .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr), .size(reg_size),
      .wr_cmd(wr_cmd), .wr_stat(wr_stat), .wr_ptr(wr_ptr),
      .rd_ok(rd_ok), .bad_acc(bad_acc)
   );

   bmdma_cmd_reg #(.PTR_W(DATA_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .wr(wr_cmd),
      .wr_run(reg_wdata[CMD_RUN_BIT]), .wr_dir(reg_wdata[CMD_DIR_BIT]),
      .done(dma_done), .ptr(ptr_q),
      .run(run), .dir(dir), .run_rise(run_rise), .run_fall(run_fall),
      .start_p(dma_start), .abort_p(dma_abort), .start_ptr(dma_desc_ptr)
   );

   bmdma_stat_reg #(.CAP_RST(CAP_RST)) u_stat (
      .clk(clk), .rst_n(rst_n), .wr(wr_stat),
      .wr_err(reg_wdata[STAT_ERR_BIT]), .wr_irq(reg_wdata[STAT_IRQ_BIT]),
      .wr_cap(reg_wdata[STAT_CAP_LO+1:STAT_CAP_LO]),
      .act_set(run_rise), .act_clr(run_fall),
      .done(dma_done), .done_err(dma_done_err),
      .act(act), .err(err), .irq(irq), .cap(cap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         acc_err <= 1'b0;
      end else begin
         if (wr_ptr) ptr_q <= {reg_wdata[DATA_W-1:PTR_ALIGN], {PTR_ALIGN{1'b0}}};
         if (bad_acc) acc_err <= 1'b1;
      end
   end

   always_comb begin
      win[0] = '0;
      win[0][CMD_RUN_BIT] = run;
      win[0][CMD_DIR_BIT] = dir;
      win[1] = '0;
      win[2] = '0;
      win[2][STAT_ACT_BIT] = act;
      win[2][STAT_ERR_BIT] = err;
      win[2][STAT_IRQ_BIT] = irq;
      win[2][STAT_CAP_LO+1:STAT_CAP_LO] = cap;
      win[3] = '0;
      for (int j = 0; j < NBYTES; j++) win[4+j] = ptr_q[8*j +: 8];
   end

   always_comb begin
      int nb;
      unique case (acc_size_e'(reg_size))
         SZ_BYTE: nb = 1;
         SZ_HALF: nb = 2;
         SZ_WORD: nb = 4;
         default: nb = 0;
      endcase
      rd_word = '0;
      if (rd_ok) begin
         for (int k = 0; k < NBYTES; k++) begin
            if (k < nb) rd_word[8*k +: 8] = win[3'(reg_addr + 3'(k))];
         end
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n)      reg_rdata <= '0;
         else if (reg_rd) reg_rdata <= rd_word;
      end
   end else begin : g_rd_comb
      assign reg_rdata = rd_word;
   end

   assign xfer_dir = dir;
   assign irq_pend = irq;

   // R9: error flag is sticky
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |=> acc_err);
   // R9: a rejected write leaves the pointer alone
   p_bad_wr_keeps_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && bad_acc) |=> $stable(ptr_q));
   // R3: active status mirrors the command run bit
   p_act_tracks_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act == run);
   // R4: start and abort never together
   p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dma_start, dma_abort}));
endmodule

// File: tb/bmdma_chan_regs_bench.sv
module bmdma_chan_regs_bench;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [1:0]  reg_size = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_err, dma_start, dma_abort, xfer_dir, irq_pend;
   logic [31:0] dma_desc_ptr;
   logic        dma_done = 1'b0, dma_done_err = 1'b0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic mon_arm = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   bmdma_chan_regs u_bmdma_chan_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .acc_err(acc_err), .dma_start(dma_start),
      .dma_abort(dma_abort), .dma_desc_ptr(dma_desc_ptr), .xfer_dir(xfer_dir),
      .dma_done(dma_done), .dma_done_err(dma_done_err), .irq_pend(irq_pend)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // monitor: compares read data one cycle after the strobe
   always @(posedge clk) mon_arm <= reg_rd;
   always @(negedge clk) begin
      if (mon_arm && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, reg_rdata, e);
      end
   end

   task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d,
                     input logic dn = 1'b0, input logic de = 1'b0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_size = s; reg_wdata = d;
      dma_done = dn; dma_done_err = de;
      @(negedge clk);
      reg_wr = 1'b0; dma_done = 1'b0; dma_done_err = 1'b0;
   endtask

   task automatic done_pulse(input logic de);
      @(negedge clk);
      dma_done = 1'b1; dma_done_err = de;
      @(negedge clk);
      dma_done = 1'b0; dma_done_err = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [1:0] s, input logic [31:0] exp,
                     input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      reg_rd = 1'b1; reg_addr = a; reg_size = s;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= WATCHDOG) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      check("R1 irq_pend", {31'd0, irq_pend}, 32'd0);
      check("R1 acc_err", {31'd0, acc_err}, 32'd0);
      rd(3'd0, 2'd2, 32'h0060_0000, "R1 word@0");
      rd(3'd2, 2'd1, 32'h0000_0060, "R1 half@2");
      rd(3'd4, 2'd2, 32'h0, "R1 ptr");
      // R2 pointer store with low bits forced to zero
      wr(3'd4, 2'd2, 32'h1234_5677);
      rd(3'd4, 2'd2, 32'h1234_5674, "R2 ptr word");
      // R10 little-endian narrow reads and reserved bytes
      rd(3'd5, 2'd0, 32'h0000_0056, "R10 byte@5");
      rd(3'd7, 2'd0, 32'h0000_0012, "R10 byte@7");
      rd(3'd6, 2'd1, 32'h0000_1234, "R10 half@6");
      rd(3'd1, 2'd0, 32'h0, "R10 reserved@1");
      // R3 start
      wr(3'd0, 2'd0, 32'h09);
      check("R3 start pulse", {31'd0, dma_start}, 32'd1);
      check("R3 start ptr", dma_desc_ptr, 32'h1234_5674);
      check("R4 no abort on start", {31'd0, dma_abort}, 32'd0);
      @(negedge clk);
      check("R3 pulse one cycle", {31'd0, dma_start}, 32'd0);
      rd(3'd0, 2'd2, 32'h0061_0009, "R3 cmd+stat");
      check("R5 xfer_dir", {31'd0, xfer_dir}, 32'd1);
      // R5 direction frozen while running
      wr(3'd0, 2'd0, 32'h01);
      check("R3 no repeat start", {31'd0, dma_start}, 32'd0);
      rd(3'd0, 2'd0, 32'h09, "R5 dir held");
      // R6 active read-only
      wr(3'd2, 2'd0, 32'h60);
      rd(3'd2, 2'd0, 32'h61, "R6 active kept");
      // R4 stop
      wr(3'd0, 2'd0, 32'h08);
      check("R4 abort pulse", {31'd0, dma_abort}, 32'd1);
      check("R4 no start", {31'd0, dma_start}, 32'd0);
      rd(3'd0, 2'd2, 32'h0060_0008, "R4 after stop");
      // restart, then completion with error
      wr(3'd0, 2'd0, 32'h01);
      check("R3 restart pulse", {31'd0, dma_start}, 32'd1);
      rd(3'd0, 2'd0, 32'h01, "R5 dir updates when idle");
      done_pulse(1'b1);
      check("R8 irq_pend", {31'd0, irq_pend}, 32'd1);
      rd(3'd0, 2'd2, 32'h0066_0000, "R8 after done");
      // R7 write-one-to-clear
      wr(3'd2, 2'd0, 32'h60);
      rd(3'd2, 2'd0, 32'h66, "R7 zeros keep");
      wr(3'd2, 2'd0, 32'h64);
      check("R7 irq cleared", {31'd0, irq_pend}, 32'd0);
      rd(3'd2, 2'd0, 32'h62, "R7 irq only");
      wr(3'd2, 2'd0, 32'h62);
      rd(3'd2, 2'd0, 32'h60, "R7 err cleared");
      // R11 capability bits writable
      wr(3'd2, 2'd0, 32'h00);
      rd(3'd2, 2'd0, 32'h00, "R11 caps cleared");
      wr(3'd2, 2'd0, 32'h20);
      rd(3'd2, 2'd0, 32'h20, "R11 cap0 set");
      // R8 completion wins over simultaneous command write
      wr(3'd0, 2'd0, 32'h01, 1'b1, 1'b0);
      check("R8 no start on collide", {31'd0, dma_start}, 32'd0);
      rd(3'd0, 2'd2, 32'h0024_0000, "R8 collide state");
      check("R9 err still clear", {31'd0, acc_err}, 32'd0);
      // R9 illegal accesses
      wr(3'd0, 2'd1, 32'h01);
      check("R9 err set", {31'd0, acc_err}, 32'd1);
      check("R9 no start", {31'd0, dma_start}, 32'd0);
      rd(3'd0, 2'd0, 32'h00, "R9 cmd unchanged");
      wr(3'd4, 2'd0, 32'hAB);
      rd(3'd4, 2'd2, 32'h1234_5674, "R9 ptr unchanged");
      wr(3'd1, 2'd0, 32'hFF);
      rd(3'd0, 2'd2, 32'h0024_0000, "R9 reserved write ignored");
      rd(3'd1, 2'd1, 32'h0, "R9 misaligned read");
      rd(3'd0, 2'd3, 32'h0, "R9 size3 read");
      check("R9 err sticky", {31'd0, acc_err}, 32'd1);
      repeat (3) @(negedge clk);
      check("R10 queue drained", exp_q.size(), 32'd0);
      finish_run();
   end
endmodule